// File: doc/BRIEF.md
# Register Write-Enable Unlock Sequencer

This block stands between a decoded serial-bus write path and a bank of clock and control registers. Those registers accept no write until software has armed a two-stage guard. The guard lives in a status register as two volatile latches. The arm latch sits at bit 1 and the unlock latch at bit 2. The block watches each write transaction through a start pulse, a stop pulse, a register address captured at the start, and a stream of data bytes marked by a valid strobe. From these it keeps both latches and drives a per-byte permit that the protected register file uses as its write enable.

Software opens the guard with two separate transactions to the status address. The first carries exactly 02h and the second carries exactly 06h. Each unlock step is judged when its transaction closes with a stop, and it takes effect on that same clock edge with no busy period. A byte with any extra bit set is not a step. A step sent in the wrong order is not a step either, and neither is a step that shares a transaction with other bytes. Writing 00h to the status address closes the guard again.

Top module: `wen_unlock_seq`

## Requirements
- R1: While `rst_n` is low and after it rises, `wel_o`, `rwel_o` and `prot_wr_o` are 0. Reset clears latches that were set.
- R2: A status-address transaction whose single data byte is exactly 02h sets `wel_o` (status bit 1). It does not change `rwel_o`.
- R3: A single-byte 06h status transaction sets `rwel_o` (status bit 2) when `wel_o` is already 1. `wel_o` stays 1, and `rwel_o` is never 1 while `wel_o` is 0.
- R4: A single-byte 06h status transaction sent while `wel_o` is 0 is ignored, and both latches stay 0.
- R5: A status byte other than 00h, 02h or 06h changes neither latch. Examples are 03h, 82h, 0Eh and 07h.
- R6: A single-byte 00h status transaction clears both latches.
- R7: A status step counts only when its transaction holds exactly one data byte and ends with a stop. A transaction with two bytes is no step. A transaction abandoned by a new start is no step either. The latches change only on a clock edge at which `bus_stop` is high.
- R8: During a transaction addressed to the protected range PROT_LO..PROT_HI (30h..37h by default), `prot_wr_o` is high in the same cycle as each valid data byte, but only while both latches are 1. Otherwise the byte is dropped with `prot_wr_o` low.
- R9: Both latches stay set across any number of protected-write transactions.
- R10: Transactions to addresses that are neither the status address (3Fh by default) nor in the protected range never raise `prot_wr_o` and leave both latches unchanged.
- R11: The latch update becomes visible right after the clock edge that samples `bus_stop`. An unlock transaction may follow the arm transaction at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | Transaction start pulse; samples `bus_addr` |
| bus_stop | input | 1 | Transaction end pulse |
| bus_addr | input | ADDR_W | Register address of the transaction |
| byte_vld | input | 1 | Data byte strobe |
| byte_data | input | DATA_W | Data byte |
| wel_o | output | 1 | Arm latch (status bit 1) |
| rwel_o | output | 1 | Unlock latch (status bit 2) |
| prot_wr_o | output | 1 | Write permit for the current protected data byte |

## Verification
The guard is driven with the legal arm-then-unlock pair. It is also driven with the unlock byte alone, and with near-miss bytes that carry one extra bit. Together these show that the block compares exact bytes and enforces the order, rather than testing single bits. Two further patterns check that steps are judged per transaction: both steps packed into one transaction, and a step abandoned by a fresh start. Protected writes are issued to both ends of the range, just outside it, and to an unrelated address, each before and after unlocking. These show that the permit depends on the address and on the latches, and that the latches persist until 00h or reset clears them.

// File: rtl/wen_unlock_pkg.sv
package wen_unlock_pkg;

   typedef enum logic [1:0] {
      STEP_NONE   = 2'd0,
      STEP_ARM    = 2'd1,
      STEP_UNLOCK = 2'd2,
      STEP_CLEAR  = 2'd3
   } step_e;

   // Exact-match decode of a status byte into a guard step.
   function automatic step_e classify_step(input logic [31:0] value,
                                           input int unsigned arm_bit,
                                           input int unsigned unl_bit);
      logic [31:0] arm_code;
      logic [31:0] unl_code;
      arm_code = 32'd1 << arm_bit;
      unl_code = arm_code | (32'd1 << unl_bit);
      if (value == 32'd0)
         return STEP_CLEAR;
      else if (value == arm_code)
         return STEP_ARM;
      else if (value == unl_code)
         return STEP_UNLOCK;
      else
         return STEP_NONE;
   endfunction

endpackage

// File: rtl/wen_frame_tracker.sv
module wen_frame_tracker #(
   parameter int unsigned         ADDR_W     = 8,
   parameter int unsigned         DATA_W     = 8,
   parameter logic [ADDR_W-1:0]   STAT_ADDR  = 'h3F,
   parameter bit                  STRICT_ONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   output logic              active_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              step_vld_o,
   output logic [DATA_W-1:0] step_byte_o
);

   localparam int unsigned CNT_W   = 2;
   localparam logic [CNT_W-1:0] CNT_SAT = '1;

   logic              active_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] first_q;
   logic              count_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         addr_q   <= '0;
         cnt_q    <= '0;
         first_q  <= '0;
      end else if (bus_start) begin
         active_q <= 1'b1;
         addr_q   <= bus_addr;
         cnt_q    <= '0;
      end else if (bus_stop) begin
         active_q <= 1'b0;
      end else if (active_q && byte_vld) begin
         if (cnt_q == '0)
            first_q <= byte_data;
         if (cnt_q != CNT_SAT)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   generate
      if (STRICT_ONE) begin : g_strict
         assign count_ok = (cnt_q == CNT_W'(1));
      end else begin : g_first
         assign count_ok = (cnt_q != '0);
      end
   endgenerate

   assign step_vld_o  = bus_stop && !bus_start && active_q && count_ok &&
                        (addr_q == STAT_ADDR);
   assign step_byte_o = first_q;
   assign active_o    = active_q;
   assign addr_o      = addr_q;

endmodule

// File: rtl/wen_latch_ctrl.sv
module wen_latch_ctrl
   import wen_unlock_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned WEL_BIT  = 1,
   parameter int unsigned RWEL_BIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_vld,
   input  logic [DATA_W-1:0] step_byte,
   output logic              wel_o,
   output logic              rwel_o
);

   step_e step;
   logic  wel_q;
   logic  rwel_q;

   always_comb begin
      step = classify_step(32'(step_byte), WEL_BIT, RWEL_BIT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel_q  <= 1'b0;
         rwel_q <= 1'b0;
      end else if (step_vld) begin
         case (step)
            STEP_CLEAR: begin
               wel_q  <= 1'b0;
               rwel_q <= 1'b0;
            end
            STEP_ARM: wel_q <= 1'b1;
            STEP_UNLOCK: begin
               if (wel_q)
                  rwel_q <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign wel_o  = wel_q;
   assign rwel_o = rwel_q;

endmodule

// File: rtl/wen_permit_gate.sv
module wen_permit_gate #(
   parameter int unsigned       ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] PROT_LO = 'h30,
   parameter logic [ADDR_W-1:0] PROT_HI = 'h37
) (
   input  logic              active,
   input  logic [ADDR_W-1:0] addr,
   input  logic              bus_start,
   input  logic              byte_vld,
   input  logic              wel,
   input  logic              rwel,
   output logic              prot_wr_o
);

   logic in_range;

   always_comb begin
      in_range  = (addr >= PROT_LO) && (addr <= PROT_HI);
      prot_wr_o = active && !bus_start && byte_vld && in_range && wel && rwel;
   end

endmodule

// File: rtl/wen_unlock_seq.sv
module wen_unlock_seq #(
   parameter int unsigned       ADDR_W     = 8,
   parameter int unsigned       DATA_W     = 8,
   parameter logic [ADDR_W-1:0] STAT_ADDR  = 'h3F,
   parameter logic [ADDR_W-1:0] PROT_LO    = 'h30,
   parameter logic [ADDR_W-1:0] PROT_HI    = 'h37,
   parameter int unsigned       WEL_BIT    = 1,
   parameter int unsigned       RWEL_BIT   = 2,
   parameter bit                STRICT_ONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   output logic              wel_o,
   output logic              rwel_o,
   output logic              prot_wr_o
);

   generate
      if (PROT_LO > PROT_HI) begin : g_bad_range
         $error("wen_unlock_seq: protected range is empty");
      end
      if ((STAT_ADDR >= PROT_LO) && (STAT_ADDR <= PROT_HI)) begin : g_bad_stat
         $error("wen_unlock_seq: status address inside protected range");
      end
      if ((WEL_BIT >= DATA_W) || (RWEL_BIT >= DATA_W) || (WEL_BIT == RWEL_BIT)) begin : g_bad_bits
         $error("wen_unlock_seq: latch bit positions invalid");
      end
   endgenerate

   logic              active;
   logic [ADDR_W-1:0] addr_q;
   logic              step_vld;
   logic [DATA_W-1:0] step_byte;

   wen_frame_tracker #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .STAT_ADDR (STAT_ADDR),
      .STRICT_ONE(STRICT_ONE)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_start  (bus_start),
      .bus_stop   (bus_stop),
      .bus_addr   (bus_addr),
      .byte_vld   (byte_vld),
      .byte_data  (byte_data),
      .active_o   (active),
      .addr_o     (addr_q),
      .step_vld_o (step_vld),
      .step_byte_o(step_byte)
   );

   wen_latch_ctrl #(
      .DATA_W  (DATA_W),
      .WEL_BIT (WEL_BIT),
      .RWEL_BIT(RWEL_BIT)
   ) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_vld (step_vld),
      .step_byte(step_byte),
      .wel_o    (wel_o),
      .rwel_o   (rwel_o)
   );

   wen_permit_gate #(
      .ADDR_W (ADDR_W),
      .PROT_LO(PROT_LO),
      .PROT_HI(PROT_HI)
   ) u_gate (
      .active   (active),
      .addr     (addr_q),
      .bus_start(bus_start),
      .byte_vld (byte_vld),
      .wel      (wel_o),
      .rwel     (rwel_o),
      .prot_wr_o(prot_wr_o)
   );

endmodule

// File: rtl/wen_unlock_seq_chk.sv
module wen_unlock_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_stop,
   input logic byte_vld,
   input logic wel_o,
   input logic rwel_o,
   input logic prot_wr_o
);

   // R1: reset leaves both latches cleared
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (!wel_o && !rwel_o));

   // R3: the unlock latch never stands without the arm latch
   p_rwel_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rwel_o |-> wel_o);

   // R4: the unlock latch only rises when the arm latch was already set
   p_rwel_rise_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rwel_o) |-> $past(wel_o));

   // R7: latches move only at a stop
   p_latch_only_at_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_stop |=> ($stable(wel_o) && $stable(rwel_o)));

   // R8: a permit needs a data byte and both latches
   p_permit_needs_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      prot_wr_o |-> (byte_vld && wel_o && rwel_o));

endmodule

bind wen_unlock_seq wen_unlock_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_stop (bus_stop),
   .byte_vld (byte_vld),
   .wel_o    (wel_o),
   .rwel_o   (rwel_o),
   .prot_wr_o(prot_wr_o)
);

// File: tb/wen_unlock_seq_bench.sv
module wen_unlock_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] STAT = 8'h3F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_start = 1'b0;
   logic       bus_stop = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_data = '0;
   logic       wel_o, rwel_o, prot_wr_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wen_unlock_seq u_wen_unlock_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_start(bus_start),
      .bus_stop (bus_stop),
      .bus_addr (bus_addr),
      .byte_vld (byte_vld),
      .byte_data(byte_data),
      .wel_o    (wel_o),
      .rwel_o   (rwel_o),
      .prot_wr_o(prot_wr_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_latches(input string req, input int w, input int r);
      chk({req, " wel"}, int'(wel_o), w);
      chk({req, " rwel"}, int'(rwel_o), r);
   endtask

   // One transaction; returns the number of bytes that saw prot_wr_o high.
   task automatic write_txn(input logic [7:0] a, input int n,
                            input logic [7:0] d0, input logic [7:0] d1,
                            input bit with_stop, output int permits);
      permits = 0;
      @(negedge clk);
      bus_start = 1'b1;
      bus_addr  = a;
      @(negedge clk);
      bus_start = 1'b0;
      for (int i = 0; i < n; i++) begin
         byte_vld  = 1'b1;
         byte_data = (i == 0) ? d0 : d1;
         #1;
         if (prot_wr_o) permits++;
         @(negedge clk);
      end
      byte_vld = 1'b0;
      bus_stop = with_stop;
      @(negedge clk);
      bus_stop = 1'b0;
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk_latches("R1 in reset", 0, 0);
      chk("R1 permit in reset", int'(prot_wr_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk_latches("R1 after reset", 0, 0);
   endtask

   task automatic t_unlock();
      int p;
      write_txn(STAT, 1, 8'h02, 8'h00, 1'b1, p);
      chk_latches("R2 arm", 1, 0);
      write_txn(STAT, 1, 8'h06, 8'h00, 1'b1, p);
      chk_latches("R3 R11 unlock", 1, 1);
   endtask

   task automatic t_protected();
      int p;
      write_txn(8'h30, 2, 8'hAA, 8'h55, 1'b1, p);
      chk("R8 low end permits", p, 2);
      write_txn(8'h37, 1, 8'h11, 8'h00, 1'b1, p);
      chk("R8 high end permits", p, 1);
      chk_latches("R9 persist", 1, 1);
      write_txn(8'h38, 1, 8'h11, 8'h00, 1'b1, p);
      chk("R10 above range", p, 0);
      write_txn(8'h10, 1, 8'h00, 8'h00, 1'b1, p);
      chk("R10 unrelated", p, 0);
      chk_latches("R10 latches kept", 1, 1);
   endtask

   task automatic t_clear();
      int p;
      write_txn(STAT, 1, 8'h00, 8'h00, 1'b1, p);
      chk_latches("R6 clear", 0, 0);
      write_txn(8'h33, 1, 8'h44, 8'h00, 1'b1, p);
      chk("R8 locked drop", p, 0);
   endtask

   task automatic t_order();
      int p;
      write_txn(STAT, 1, 8'h06, 8'h00, 1'b1, p);
      chk_latches("R4 unlock first", 0, 0);
      write_txn(8'h31, 1, 8'h44, 8'h00, 1'b1, p);
      chk("R4 still locked", p, 0);
   endtask

   task automatic t_bad_bytes();
      int p;
      write_txn(STAT, 1, 8'h03, 8'h00, 1'b1, p);
      write_txn(STAT, 1, 8'h82, 8'h00, 1'b1, p);
      chk_latches("R5 near arm", 0, 0);
      write_txn(STAT, 1, 8'h02, 8'h00, 1'b1, p);
      write_txn(STAT, 1, 8'h0E, 8'h00, 1'b1, p);
      write_txn(STAT, 1, 8'h07, 8'h00, 1'b1, p);
      chk_latches("R5 near unlock", 1, 0);
      write_txn(8'h34, 1, 8'h44, 8'h00, 1'b1, p);
      chk("R5 arm only no permit", p, 0);
      write_txn(STAT, 1, 8'h00, 8'h00, 1'b1, p);
   endtask

   task automatic t_framing();
      int p;
      write_txn(STAT, 2, 8'h02, 8'h02, 1'b1, p);
      chk_latches("R7 two bytes", 0, 0);
      write_txn(STAT, 1, 8'h02, 8'h00, 1'b0, p);
      write_txn(8'h10, 0, 8'h00, 8'h00, 1'b1, p);
      chk_latches("R7 abandoned", 0, 0);
      write_txn(STAT, 1, 8'h02, 8'h00, 1'b1, p);
      write_txn(STAT, 2, 8'h06, 8'h06, 1'b1, p);
      chk_latches("R7 two-byte unlock", 1, 0);
      write_txn(STAT, 1, 8'h06, 8'h00, 1'b1, p);
      chk_latches("R11 back to back", 1, 1);
      do_reset();
      chk_latches("R1 reset clears set", 0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_unlock();
      t_protected();
      t_clear();
      t_order();
      t_bad_bytes();
      t_framing();
      repeat (2) @(negedge clk);
      finish_run();
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

endmodule